// File: doc/BRIEF.md
# Flagged Dual-Clock FIFO with Packet Replay

This block is a first-in first-out buffer of 18-bit words. A producer writes on its own clock and a consumer reads on a separate clock. The buffer reports its fill level through five active-low status outputs, graded from empty to full. Two of these outputs have thresholds set by offset registers. The offsets are loaded from the write side and come out of reset at parameterised default values. Write and read pointers carry one bit more than the address. Each pointer is passed to the other clock domain as Gray code through a two-flop synchroniser. Each side therefore judges the fill level conservatively: the read side may under-count and the write side may over-count.

A replay input rewinds the read pointer to storage location zero, so a packet can be read out again. Reset places both pointers at location zero. A packet of up to the full depth, written since the last reset, can therefore be replayed any number of times. Words written after the rewind follow the replayed words. The write side must be idle while the replay pulse is applied and for a few cycles after it. The offsets may only be changed while the buffer is in reset or idle. DEPTH must be a power of two, and it must exceed the sum of the two offsets.

Top module: `flagfifo_rt`

## Requirements
- R1: After the synchronous reset `rst`, both pointers are at location zero and `rd_data` is 0. The status outputs are `empty_n`=0, `aempty_n`=0, `half_n`=1, `afull_n`=1 and `full_n`=1. The empty offset is EMPTY_OFS and the full offset is FULL_OFS.
- R2: Words are read in the order they were written. An accepted read (`rd_en` high while `empty_n` is high and `rt` is low) presents its word on `rd_data` after that `rclk` edge. `rd_data` then holds until the next accepted read.
- R3: A write while `full_n` is low is ignored. Storage, pointers and status outputs are unchanged.
- R4: A read while `empty_n` is low is ignored. `rd_data` and the read pointer are unchanged.
- R5: Once both sides have settled, `empty_n` is low exactly when the buffer holds zero words. It is updated on `rclk`.
- R6: Once settled, `aempty_n` is low when the occupancy is at most the empty offset. It changes only on `rclk`.
- R7: Once settled, `half_n` is low when the occupancy exceeds DEPTH/2. It is updated on `wclk`.
- R8: Once settled, `afull_n` is low when the occupancy is at least DEPTH minus the full offset. It changes only on `wclk`.
- R9: Once settled, `full_n` is low exactly when the occupancy equals DEPTH. A full buffer also drives `afull_n` and `half_n` low.
- R10: A `wclk` cycle with `ofs_ld` high loads `ofs_val` into one offset. `ofs_sel`=0 selects the empty offset and `ofs_sel`=1 selects the full offset. The new value governs the status outputs from then on.
- R11: A one-cycle high pulse on `rt` sets the read pointer to location zero, and any read in that cycle is ignored. The status outputs are recomputed from the rewound pointer. Later reads return the stored words again, from the first one written since reset.
- R12: Words written after a rewind are delivered after the replayed words, in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Word to store |
| ofs_ld | input | 1 | Offset load strobe (write domain) |
| ofs_sel | input | 1 | Offset select: 0 empty offset, 1 full offset |
| ofs_val | input | $clog2(DEPTH) | Offset value to load |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Replay pulse: rewind read pointer to location zero |
| rd_data | output | 18 | Registered read word |
| empty_n | output | 1 | Low when empty |
| aempty_n | output | 1 | Low when occupancy is at most the empty offset |
| half_n | output | 1 | Low when more than half full |
| afull_n | output | 1 | Low when occupancy is at least DEPTH minus the full offset |
| full_n | output | 1 | Low when full |

## Verification
The bench builds the block with DEPTH=16 and both default offsets at 3. With these values, every band of the status ladder (empty, almost empty, middle, over half, almost full, full) is reached within sixteen writes. The bench steps through each band when filling and again when draining, then moves the band edges by loading offsets of 5 and 2. Because the depth is small, a full-depth replay, a repeated replay and a replay followed by fresh writes all fit in a short run.

// File: rtl/ffr_pkg.sv
package ffr_pkg;

    localparam int WORD_W = 18;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        OFS_SEL_EMPTY = 1'b0,
        OFS_SEL_FULL  = 1'b1
    } ofs_sel_e;

    // status kept in the write domain
    typedef struct packed {
        logic half_n;
        logic afull_n;
        logic full_n;
    } wflag_t;

    // status kept in the read domain
    typedef struct packed {
        logic empty_n;
        logic aempty_n;
    } rflag_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ffr_sync.sv
module ffr_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/ffr_mem.sv
module ffr_mem #(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic            wclk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  ffr_pkg::word_t  wdata,
    input  logic            rclk,
    input  logic            rst,
    input  logic            re,
    input  logic [AW-1:0]   raddr,
    output ffr_pkg::word_t  rdata
);
    ffr_pkg::word_t store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/ffr_wside.sv
module ffr_wside #(
    parameter int DEPTH    = 512,
    parameter int AW       = 9,
    parameter int EOFS_DEF = 127,
    parameter int FOFS_DEF = 127,
    localparam int PW      = AW + 1
) (
    input  logic              wclk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              ofs_ld,
    input  logic              ofs_sel,
    input  logic [AW-1:0]     ofs_val,
    input  logic [PW-1:0]     rgray_s,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [PW-1:0]     wgray,
    output logic [AW-1:0]     eofs,
    output logic [AW-1:0]     fofs,
    output ffr_pkg::wflag_t   flg
);
    import ffr_pkg::*;

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

    logic [PW-1:0] wbin, wbin_nx, rbin_s, occ_nx;
    logic          acc;
    ofs_sel_e      sel_e;

    assign sel_e   = ofs_sel_e'(ofs_sel);
    assign acc     = wr_en && flg.full_n;
    assign wbin_nx = wbin + PW'(acc);
    assign rbin_s  = PW'(gray2bin(32'(rgray_s)));
    assign occ_nx  = wbin_nx - rbin_s;
    assign we      = acc;
    assign waddr   = wbin[AW-1:0];

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin <= '0;
            wgray <= '0;
            flg  <= '{half_n: 1'b1, afull_n: 1'b1, full_n: 1'b1};
            eofs <= AW'(EOFS_DEF);
            fofs <= AW'(FOFS_DEF);
        end else begin
            wbin        <= wbin_nx;
            wgray       <= PW'(bin2gray(32'(wbin_nx)));
            flg.full_n  <= (occ_nx != DEPTH_P);
            flg.afull_n <= (occ_nx < (DEPTH_P - {1'b0, fofs}));
            flg.half_n  <= (occ_nx <= HALF_P);
            if (ofs_ld) begin
                if (sel_e == OFS_SEL_EMPTY) eofs <= ofs_val;
                else                        fofs <= ofs_val;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (rst)
        (wbin - rbin_s) <= DEPTH_P);                                           // R9
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk) disable iff (rst)
        (wr_en && !flg.full_n) |=> $stable(wbin));                             // R3
    AST_FULL_GRADED: assert property (@(posedge wclk) disable iff (rst)
        !flg.full_n |-> (!flg.afull_n && !flg.half_n));                        // R9
    AST_FULL_OFS_LOAD: assert property (@(posedge wclk) disable iff (rst)
        (ofs_ld && ofs_sel) |=> (fofs == $past(ofs_val)));                     // R10
endmodule

// File: rtl/ffr_rside.sv
module ffr_rside #(
    parameter int DEPTH = 512,
    parameter int AW    = 9,
    localparam int PW   = AW + 1
) (
    input  logic              rclk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rt,
    input  logic [PW-1:0]     wgray_s,
    input  logic [AW-1:0]     eofs,
    output logic              re,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rgray,
    output ffr_pkg::rflag_t   flg
);
    import ffr_pkg::*;

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] rbin, rbin_nx, wbin_s, occ_nx;
    logic          acc;

    assign acc     = rd_en && flg.empty_n && !rt;
    assign rbin_nx = rt ? '0 : (rbin + PW'(acc));
    assign wbin_s  = PW'(gray2bin(32'(wgray_s)));
    assign occ_nx  = wbin_s - rbin_nx;
    assign re      = acc;
    assign raddr   = rbin[AW-1:0];

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            flg   <= '{empty_n: 1'b0, aempty_n: 1'b0};
        end else begin
            rbin         <= rbin_nx;
            rgray        <= PW'(bin2gray(32'(rbin_nx)));
            flg.empty_n  <= (occ_nx != '0);
            flg.aempty_n <= (occ_nx > {1'b0, eofs});
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rst)
        (wbin_s - rbin) <= DEPTH_P);                                           // R5
    AST_EMPTY_BLOCKS_READ: assert property (@(posedge rclk) disable iff (rst)
        (rd_en && !rt && !flg.empty_n) |=> $stable(rbin));                     // R4
    AST_RT_REWIND: assert property (@(posedge rclk) disable iff (rst)
        rt |=> (rbin == '0));                                                  // R11
    AST_EMPTY_GRADED: assert property (@(posedge rclk) disable iff (rst)
        !flg.empty_n |-> !flg.aempty_n);                                       // R6
endmodule

// File: rtl/flagfifo_rt.sv
module flagfifo_rt #(
    parameter int DEPTH     = 512,
    parameter int EMPTY_OFS = 127,
    parameter int FULL_OFS  = 127,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [17:0]   wr_data,
    input  logic          ofs_ld,
    input  logic          ofs_sel,
    input  logic [AW-1:0] ofs_val,
    input  logic          rd_en,
    input  logic          rt,
    output logic [17:0]   rd_data,
    output logic          empty_n,
    output logic          aempty_n,
    output logic          half_n,
    output logic          afull_n,
    output logic          full_n
);
    import ffr_pkg::*;

    localparam int PW = AW + 1;

    logic [PW-1:0]  wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0]  waddr, raddr, eofs, fofs;
    logic           we, re;
    wflag_t         wf;
    rflag_t         rf;
    word_t          rdata;

    ffr_wside #(.DEPTH(DEPTH), .AW(AW), .EOFS_DEF(EMPTY_OFS), .FOFS_DEF(FULL_OFS)) u_wside (
        .wclk(wclk), .rst(rst), .wr_en(wr_en), .ofs_ld(ofs_ld), .ofs_sel(ofs_sel),
        .ofs_val(ofs_val), .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
        .eofs(eofs), .fofs(fofs), .flg(wf)
    );

    ffr_rside #(.DEPTH(DEPTH), .AW(AW)) u_rside (
        .rclk(rclk), .rst(rst), .rd_en(rd_en), .rt(rt), .wgray_s(wgray_s),
        .eofs(eofs), .re(re), .raddr(raddr), .rgray(rgray), .flg(rf)
    );

    ffr_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));
    ffr_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));

    ffr_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rclk(rclk), .rst(rst), .re(re), .raddr(raddr), .rdata(rdata)
    );

    assign rd_data  = rdata;
    assign empty_n  = rf.empty_n;
    assign aempty_n = rf.aempty_n;
    assign half_n   = wf.half_n;
    assign afull_n  = wf.afull_n;
    assign full_n   = wf.full_n;

    AST_EMPTY_HOLDS_DATA: assert property (@(posedge rclk) disable iff (rst)
        (rd_en && !rt && !empty_n) |=> $stable(rd_data));                      // R4
    AST_RT_NO_DATA: assert property (@(posedge rclk) disable iff (rst)
        rt |=> $stable(rd_data));                                              // R11
endmodule

// File: tb/flagfifo_rt_tb_top.sv
`timescale 1ns/1ps
module flagfifo_rt_tb_top;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, ofs_ld = 1'b0, ofs_sel = 1'b0, rd_en = 1'b0, rt = 1'b0;
    logic [17:0] wr_data = '0;
    logic [3:0]  ofs_val = '0;
    logic [17:0] rd_data;
    logic        empty_n, aempty_n, half_n, afull_n, full_n;

    int total = 0, bad = 0;
    int eofs = 3, fofs = 3;
    int wlog[$];
    int ridx = 0;
    int last_rd = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flagfifo_rt #(.DEPTH(D), .EMPTY_OFS(3), .FULL_OFS(3)) dut_i (
        .wclk(clk), .rclk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ofs_ld(ofs_ld), .ofs_sel(ofs_sel), .ofs_val(ofs_val), .rd_en(rd_en), .rt(rt),
        .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n), .half_n(half_n),
        .afull_n(afull_n), .full_n(full_n)
    );

    function automatic int occ();
        return wlog.size() - ridx;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // flags packed as {empty_n, aempty_n, half_n, afull_n, full_n}
    task automatic chk_flags(input string req);
        int o, exp;
        repeat (6) @(negedge clk);
        o = occ();
        exp = {27'd0, (o != 0), (o > eofs), (o <= D/2), (o < D - fofs), (o < D)};
        check(req, {27'd0, empty_n, aempty_n, half_n, afull_n, full_n}, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wlog.delete();
        ridx = 0; last_rd = 0; eofs = 3; fofs = 3;
    endtask

    // one clock: drive at negedge, sample at following negedge
    task automatic cyc(input bit w, input int wd, input bit r, input string req);
        bit w_ok, r_ok;
        int exp_v;
        w_ok = w && (occ() < D);
        r_ok = r && (occ() > 0);
        exp_v = r_ok ? wlog[ridx] : last_rd;
        wr_en = w; wr_data = 18'(wd); rd_en = r;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (w_ok) wlog.push_back(wd);
        if (r) begin
            check(req, int'(rd_data), exp_v);
            if (r_ok) ridx++;
        end
        last_rd = int'(rd_data);
    endtask

    task automatic rewind();
        rt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rt = 1'b0;
        ridx = 0;
    endtask

    task automatic load_ofs(input bit sel, input int val);
        ofs_ld = 1'b1; ofs_sel = sel; ofs_val = 4'(val);
        @(posedge clk);
        @(negedge clk);
        ofs_ld = 1'b0;
        if (sel) fofs = val; else eofs = val;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 rd_data", int'(rd_data), 0);
        chk_flags("R1 flags");

        // fill ladder: R5 R6 R7 R8 R9
        for (int k = 0; k < D; k++) begin
            cyc(1'b1, 'h100 + k, 1'b0, "R2");
            chk_flags("R5/R6/R7/R8/R9 fill");
        end
        // R3 write while full
        cyc(1'b1, 'h3FFFF, 1'b0, "R3");
        chk_flags("R3 flags after write to full");

        // drain ladder, data order R2
        for (int k = 0; k < D; k++) begin
            cyc(1'b0, 0, 1'b1, "R2 drain data");
            chk_flags("R5/R6/R7/R8/R9 drain");
        end
        // R4 read while empty
        cyc(1'b0, 0, 1'b1, "R4 rd_data held");
        chk_flags("R4 flags after read of empty");

        // R11 full-depth replay, partial, then again
        rewind();
        chk_flags("R11 flags after rewind");
        for (int k = 0; k < 5; k++) cyc(1'b0, 0, 1'b1, "R11 replay data");
        rewind();
        chk_flags("R11 flags after second rewind");
        for (int k = 0; k < D; k++) cyc(1'b0, 0, 1'b1, "R11 full replay data");
        chk_flags("R11 flags after replay drained");

        // R12 writes after a rewind
        do_reset();
        for (int k = 0; k < 4; k++) cyc(1'b1, 'h200 + k, 1'b0, "R12");
        chk_flags("R12 flags before reads");
        cyc(1'b0, 0, 1'b1, "R12 first read");
        cyc(1'b0, 0, 1'b1, "R12 second read");
        rewind();
        repeat (4) @(negedge clk);
        for (int k = 0; k < 3; k++) cyc(1'b1, 'h300 + k, 1'b0, "R12");
        chk_flags("R12 flags after late writes");
        for (int k = 0; k < 7; k++) cyc(1'b0, 0, 1'b1, "R12 replay then new data");
        chk_flags("R12 flags drained");

        // R10 loaded offsets
        do_reset();
        load_ofs(1'b0, 5);
        load_ofs(1'b1, 2);
        chk_flags("R10 flags empty");
        for (int k = 0; k < D; k++) begin
            cyc(1'b1, 'h400 + k, 1'b0, "R10");
            chk_flags("R10 fill with loaded offsets");
        end
        // R1 defaults restored by reset
        do_reset();
        for (int k = 0; k < 4; k++) cyc(1'b1, 'h500 + k, 1'b0, "R1");
        chk_flags("R1 default offsets restored");

        // R2 streaming with simultaneous write and read
        do_reset();
        for (int k = 0; k < 8; k++) cyc(1'b1, 'h600 + k, 1'b0, "R2");
        chk_flags("R2 flags before stream");
        for (int k = 0; k < 8; k++) cyc(1'b1, 'h700 + k, 1'b1, "R2 stream data");
        chk_flags("R2 flags after stream");
        for (int k = 0; k < 8; k++) cyc(1'b0, 0, 1'b1, "R2 tail data");
        chk_flags("R2 flags drained");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule